// File: doc/BRIEF.md
# Packed Decimal String Adder/Subtractor

This block walks two equal-length strings of packed binary-coded-decimal digits held in a byte-wide memory. Each string holds two digits per byte, and the least significant digit pair sits at the lowest address. The engine can add the source string into the destination, subtract the source from the destination, or compare the two. Compare computes the same difference as subtract but leaves memory unchanged.

A caller drives an operation code, a digit count and two byte addresses, then pulses `start`. The engine latches these values into its own pointers and its own 16-bit step counter, so the caller's values are never changed. On each step it reads one source byte, then one destination byte, and forms a two-digit decimal sum or difference with a carry or borrow that ripples between steps. For add and subtract it then writes the result byte back.

When the last step completes, the engine raises `done` for one cycle and updates two flags. The carry flag holds the final carry or borrow. The zero flag is set when every result byte was zero. Out-of-range digit counts do not fault: they make the step counter wrap to its all-ones value, and the engine runs that many steps.

Top module: `bcd_string_engine`

## Requirements
- R1: With `op` = 2'b00 (add), each destination byte becomes the decimal sum of the destination and source strings, modulo 10^(2·steps). `carry_flag` is set when the sum overflows that width.
- R2: With `op` = 2'b01 (subtract), the destination becomes destination minus source, modulo 10^(2·steps). `carry_flag` is set when the source is larger, meaning a borrow came out of the top digit.
- R3: With `op` = 2'b10 (compare), the flags are set exactly as for subtract, and no memory write is issued.
- R4: `zero_flag` is 1 exactly when every result byte of the run is 00, including the compare result.
- R5: A run takes (count+1)>>1 byte steps. Each step reads source then destination at increasing addresses starting from the given ones. The source bytes, and the byte just past the destination string, are never written.
- R6: A digit count of 0 or of all-ones (255 with an 8-bit count) loads the all-ones value of the step counter. That is 65535 steps by default, and every step is performed.
- R7: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is high. Results are correct for any acknowledge latency.
- R8: `start` while idle makes `busy` high on the next cycle. `done` is a one-cycle pulse with `busy` low. The flags hold until the next run ends. A `start` while busy is ignored.
- R9: After reset, `busy`, `done`, `mem_req`, `carry_flag` and `zero_flag` are all 0.
- R10: `op` = 2'b11 behaves as compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| op | input | 2 | 00 add, 01 subtract, 10 or 11 compare |
| digit_cnt | input | DIG_W | String length in packed digits |
| src_addr | input | ADDR_W | Byte address of the lowest source byte |
| dst_addr | input | ADDR_W | Byte address of the lowest destination byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| carry_flag | output | 1 | Final carry or borrow |
| zero_flag | output | 1 | Whole result was zero |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Transfer byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer completes this cycle |

## Verification
The assertions take for granted that the memory raises `mem_ack` only while `mem_req` is high, for one cycle per transfer. They also assume that `mem_ack` is low during reset. The bench memory model answers only pending requests, after a programmable wait, and drops its acknowledge for a cycle after each one. The checks further rely on every nibble in memory being a valid decimal digit, so all string contents are built from digits 0 to 9. The tests sweep acknowledge latencies of zero and three cycles, so the hold-while-waiting rule is exercised.

// File: rtl/bcd_str_pkg.sv
// Package: shared types for the packed decimal string engine.
// Assumes nothing beyond the encodings listed here.
package bcd_str_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_CMP  = 2'b10,
        OP_CMPX = 2'b11
    } bcd_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSRC,
        ST_RDST,
        ST_CALC,
        ST_WR
    } bcd_state_t;
endpackage

// File: rtl/bcd_pair_alu.sv
// Module: two-digit (or NIB-digit) decimal add/subtract with rippling carry.
// Assumes every input nibble is a valid decimal digit (0..9).
module bcd_pair_alu #(
    parameter int NIB = 2
) (
    input  logic [4*NIB-1:0] a_i,    // destination digits
    input  logic [4*NIB-1:0] b_i,    // source digits
    input  logic             cin_i,  // carry or borrow in
    input  logic             sub_i,  // 1: a - b, 0: a + b
    output logic [4*NIB-1:0] r_o,
    output logic             cout_o
);
    logic [NIB:0] cy;
    assign cy[0] = cin_i;

    for (genvar g = 0; g < NIB; g++) begin : g_nib
        logic [3:0] da, db, dr;
        logic [4:0] t;
        logic       co;
        assign da = a_i[4*g +: 4];
        assign db = b_i[4*g +: 4];

        // Per-digit binary step followed by the decimal adjust of 6.
        always_comb begin
            if (sub_i) begin
                t  = {1'b0, da} - {1'b0, db} - {4'b0, cy[g]};
                co = t[4];
                dr = t[4] ? (t[3:0] - 4'd6) : t[3:0];
            end else begin
                t  = {1'b0, da} + {1'b0, db} + {4'b0, cy[g]};
                co = (t > 5'd9);
                dr = co ? (t[3:0] + 4'd6) : t[3:0];
            end
        end

        assign r_o[4*g +: 4] = dr;
        assign cy[g+1]       = co;
    end

    assign cout_o = cy[NIB];
endmodule

// File: rtl/bcd_step_count.sv
// Module: converts a digit count into a byte step count.
// Counts of 0 or all-ones wrap to the counter's all-ones value.
module bcd_step_count #(
    parameter int DIG_W = 8,
    parameter int CNT_W = 16
) (
    input  logic [DIG_W-1:0] cnt_i,
    output logic [CNT_W-1:0] steps_o
);
    localparam logic [DIG_W-1:0] CNT_ALL1 = '1;
    logic [DIG_W:0] half;

    // Round the digit count up to whole bytes, or apply the wrap rule.
    always_comb begin
        half = ({1'b0, cnt_i} + 1'b1) >> 1;
        if (cnt_i == '0 || cnt_i == CNT_ALL1) steps_o = '1;
        else                                  steps_o = CNT_W'(half);
    end
endmodule

// File: rtl/bcd_string_engine.sv
// Module: sequences reads, decimal arithmetic and write-back over a string.
// Assumes memory acknowledges one request per transfer and holds rdata with ack.
module bcd_string_engine
    import bcd_str_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DIG_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [DIG_W-1:0]  digit_cnt,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              done,
    output logic              carry_flag,
    output logic              zero_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack
);
    bcd_state_t        state;
    bcd_op_t           op_q;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;
    logic [CNT_W-1:0]  remain, steps;
    logic [7:0]        src_q, dst_q, res_q, alu_r;
    logic              carry_q, nz_q, alu_co, do_write, last_step;

    bcd_step_count #(.DIG_W(DIG_W), .CNT_W(CNT_W)) u_steps (
        .cnt_i   (digit_cnt),
        .steps_o (steps)
    );

    bcd_pair_alu #(.NIB(2)) u_alu (
        .a_i    (dst_q),
        .b_i    (src_q),
        .cin_i  (carry_q),
        .sub_i  (op_q != OP_ADD),
        .r_o    (alu_r),
        .cout_o (alu_co)
    );

    assign do_write  = (op_q == OP_ADD) || (op_q == OP_SUB);
    assign last_step = (remain == CNT_W'(1));

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = (state == ST_RSRC) || (state == ST_RDST) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = (state == ST_RSRC) ? src_ptr : dst_ptr;
        mem_wdata = res_q;
    end

    assign busy = (state != ST_IDLE);

    // Step sequencer: load, read pair, compute, optional write, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_q       <= OP_ADD;
            src_ptr    <= '0;
            dst_ptr    <= '0;
            remain     <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            res_q      <= '0;
            carry_q    <= 1'b0;
            nz_q       <= 1'b0;
            done       <= 1'b0;
            carry_flag <= 1'b0;
            zero_flag  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    src_ptr <= src_addr;
                    dst_ptr <= dst_addr;
                    remain  <= steps;
                    op_q    <= bcd_op_t'(op);
                    carry_q <= 1'b0;
                    nz_q    <= 1'b0;
                    state   <= ST_RSRC;
                end
                ST_RSRC: if (mem_ack) begin
                    src_q <= mem_rdata;
                    state <= ST_RDST;
                end
                ST_RDST: if (mem_ack) begin
                    dst_q <= mem_rdata;
                    state <= ST_CALC;
                end
                ST_CALC: begin
                    res_q   <= alu_r;
                    carry_q <= alu_co;
                    nz_q    <= nz_q | (|alu_r);
                    if (do_write) begin
                        state <= ST_WR;
                    end else if (last_step) begin
                        carry_flag <= alu_co;
                        zero_flag  <= !(nz_q | (|alu_r));
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        src_ptr <= src_ptr + 1'b1;
                        dst_ptr <= dst_ptr + 1'b1;
                        remain  <= remain - 1'b1;
                        state   <= ST_RSRC;
                    end
                end
                ST_WR: if (mem_ack) begin
                    if (last_step) begin
                        carry_flag <= carry_q;
                        zero_flag  <= !nz_q;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        src_ptr <= src_ptr + 1'b1;
                        dst_ptr <= dst_ptr + 1'b1;
                        remain  <= remain - 1'b1;
                        state   <= ST_RSRC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcd_string_engine_chk.sv
// Checker: port-level protocol and control properties of the string engine.
// Assumes mem_ack is only raised against a pending request.
module bcd_string_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic              busy,
    input logic              done,
    input logic              carry_flag,
    input logic              zero_flag,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ack
);
    logic cmp_q;

    // Remember whether the accepted run is a compare.
    always_ff @(posedge clk) begin
        if (!rst_n)              cmp_q <= 1'b0;
        else if (start && !busy) cmp_q <= op[1];
    end

    p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !cmp_q);

    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(carry_flag) && $stable(zero_flag));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

bind bcd_string_engine bcd_string_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .busy       (busy),
    .done       (done),
    .carry_flag (carry_flag),
    .zero_flag  (zero_flag),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/sim_bcd_string_engine.sv
// Bench: sweeps byte pairs and string lengths, computing results by decimal digits.
module sim_bcd_string_engine;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [DW-1:0] digit_cnt = '0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic          busy, done, carry_flag, zero_flag;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    int vectors = 0, fails = 0, lat = 0, writes = 0;
    logic [7:0] mem [0:(1<<AW)-1];
    logic [7:0] o_src [0:255];
    logic [7:0] o_dst [0:255];
    logic [7:0] e_res [0:255];
    bit e_c, e_z;
    int seed = 12345;

    always #2 clk = ~clk;

    bcd_string_engine #(.ADDR_W(AW), .DIG_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .digit_cnt(digit_cnt),
        .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done),
        .carry_flag(carry_flag), .zero_flag(zero_flag), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: acknowledges a pending request after lat extra cycles.
    int wcnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; wcnt <= 0; mem_rdata <= 8'h00;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack <= 1'b1; wcnt <= 0;
                if (mem_we) begin mem[mem_addr] <= mem_wdata; writes <= writes + 1; end
                else mem_rdata <= mem[mem_addr];
            end else wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rnd_bcd();
        seed = seed * 1103515245 + 12345;
        return 8'((((seed >>> 16) & 32'h7fff) % 100 / 10) * 16 + (((seed >>> 16) & 32'h7fff) % 10));
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    // Expected result from digit-by-digit decimal arithmetic.
    task automatic model(input int opv, input int nb);
        int c = 0;
        e_z = 1;
        for (int i = 0; i < nb; i++) begin
            int dg [2];
            for (int h = 0; h < 2; h++) begin
                int d = (o_dst[i] >> (4*h)) & 15;
                int s = (o_src[i] >> (4*h)) & 15;
                int t = (opv == 0) ? d + s + c : d - s - c;
                if (opv == 0) begin c = t / 10; t = t % 10; end
                else if (t < 0) begin t += 10; c = 1; end
                else c = 0;
                dg[h] = t;
            end
            e_res[i] = 8'(dg[1] * 16 + dg[0]);
            if (e_res[i] != 0) e_z = 0;
        end
        e_c = (c != 0);
    endtask

    task automatic run(input int opv, input int cnt, input int sa, input int da, input bit disturb);
        int nb = (cnt == 0 || cnt == 255) ? 255 : (cnt + 1) / 2;
        int w0, wait_n;
        bit wr = (opv == 0 || opv == 1);
        string tag = (opv == 0) ? "R1" : (opv == 1) ? "R2" : "R3";
        logic [7:0] past_end;
        for (int i = 0; i < nb; i++) begin
            o_src[i] = mem[(sa + i) % (1<<AW)];
            o_dst[i] = mem[(da + i) % (1<<AW)];
        end
        past_end = mem[(da + nb) % (1<<AW)];
        model(opv >= 2 ? 1 : opv, nb);
        @(negedge clk);
        w0 = writes;
        op = 2'(opv); digit_cnt = DW'(cnt); src_addr = AW'(sa); dst_addr = AW'(da); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
            if (disturb && wait_n == 3) begin op = 2'b01; src_addr = AW'(da); start = 1'b1; end
            if (disturb && wait_n == 4) start = 1'b0;
        end
        chk(done, "R8 done pulse", done, 1);
        chk(!busy, "R8 idle at done", busy, 0);
        begin
            int bad = -1;
            for (int i = 0; i < nb; i++) begin
                logic [7:0] want = wr ? e_res[i] : o_dst[i];
                if (mem[(da + i) % (1<<AW)] !== want && bad < 0) bad = i;
            end
            chk(bad < 0, tag, bad < 0 ? 0 : mem[(da + bad) % (1<<AW)],
                bad < 0 ? 0 : (wr ? e_res[bad] : o_dst[bad]));
        end
        chk(carry_flag == e_c, {tag, " carry"}, carry_flag, e_c);
        chk(zero_flag == e_z, "R4 zero flag", zero_flag, e_z);
        chk(writes - w0 == (wr ? nb : 0), wr ? "R5 write count" : "R3 no write", writes - w0, wr ? nb : 0);
        chk(mem[(da + nb) % (1<<AW)] == past_end, "R5 byte past string", mem[(da + nb) % (1<<AW)], past_end);
        if ((da - sa + (1<<AW)) % (1<<AW) >= nb) begin
            int bad = 0;
            for (int i = 0; i < nb; i++) if (mem[(sa + i) % (1<<AW)] != o_src[i]) bad++;
            chk(bad == 0, "R5 source untouched", bad, 0);
        end
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 0);
    endtask

    task automatic fill(input int a, input int n);
        for (int i = 0; i < n; i++) mem[(a + i) % (1<<AW)] = rnd_bcd();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R9 reset control", {busy, done, mem_req}, 0);
        chk(!carry_flag && !zero_flag, "R9 reset flags", {carry_flag, zero_flag}, 0);

        // Single-byte sweep of digit pairs for each operation.
        for (int o = 0; o < 3; o++)
            for (int a = 0; a < 100; a++)
                for (int b = 0; b < 100; b += 7) begin
                    mem[10'h100] = to_bcd(b); mem[10'h200] = to_bcd(a);
                    run(o, 2, 10'h100, 10'h200, 0);
                end

        // Multi-byte random strings with two acknowledge latencies (R7).
        foreach (lat_sel[k]) ;
        for (int l = 0; l < 2; l++) begin
            lat = (l == 0) ? 0 : 3;
            for (int o = 0; o < 3; o++) begin
                int cl [9] = '{1, 3, 4, 7, 8, 12, 40, 101, 254};
                foreach (cl[k]) begin
                    fill(10'h000, 128); fill(10'h200, 128);
                    run(o, cl[k], 10'h000, 10'h200, 0);
                end
            end
        end
        lat = 1;
        fill(10'h000, 8); fill(10'h200, 8);
        run(0, 16, 10'h000, 10'h200, 0);   // R7 latency 1
        lat = 0;

        // Full ripple: 999999 + 000001 -> zero with carry.
        for (int i = 0; i < 3; i++) begin mem[10'h300 + i] = 8'h99; mem[10'h100 + i] = (i == 0) ? 8'h01 : 8'h00; end
        run(0, 6, 10'h100, 10'h300, 0);
        // Equal strings: subtract and compare give zero, no borrow.
        for (int i = 0; i < 4; i++) begin mem[10'h300 + i] = 8'h42; mem[10'h100 + i] = 8'h42; end
        run(2, 8, 10'h100, 10'h300, 0);
        run(1, 8, 10'h100, 10'h300, 0);
        // Zero minus one: all nines with borrow.
        for (int i = 0; i < 4; i++) begin mem[10'h300 + i] = 8'h00; mem[10'h100 + i] = (i == 0) ? 8'h01 : 8'h00; end
        run(1, 8, 10'h100, 10'h300, 0);

        // R10: op 2'b11 acts as compare.
        fill(10'h100, 4); fill(10'h300, 4);
        run(3, 8, 10'h100, 10'h300, 0);

        // R8: start while busy is ignored.
        fill(10'h100, 4); fill(10'h300, 4);
        run(0, 8, 10'h100, 10'h300, 1);

        // R6: counts 0 and 255 wrap the step counter to all-ones (255 here).
        fill(10'h000, 256); fill(10'h200, 256);
        run(0, 0, 10'h000, 10'h200, 0);
        fill(10'h000, 256); fill(10'h200, 256);
        run(1, 255, 10'h000, 10'h200, 0);
        chk(writes > 0, "R6 wrap ran", writes, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    int lat_sel [1];
endmodule